// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the integer execute stage of a small 32-bit processor. Each cycle in which `op_valid` is high, it takes an operation code, two operands, a shift amount and a set-flags bit. It works out an arithmetic, multiply, logical, shift or rotate result. The result comes out combinationally, together with a write enable for the destination register.

A four-bit condition register holds negative, zero, carry and overflow. The register is loaded on the rising clock edge, and only when the operation asks for a flag update. The three comparison operations always update the flags and never request a register write. Add-with-carry and subtract-with-carry take their carry-in from the stored carry flag. That lets multi-word arithmetic be chained across consecutive operations.

Top module: `flag_alu`

## Requirements
- R1: Opcode encoding: 0 add (a+b), 1 add-with-carry (a+b+C), 2 subtract (a-b), 3 subtract-with-carry (a-b-(1-C)), 4 reverse subtract (b-a). These five produce the W-bit wrapped result with `wr_en` high.
- R2: For the opcodes in R1 and opcodes 15 and 16, carry-out is set as follows. For additions it is the unsigned carry out of bit W-1. For subtractions and compare it is 1 when no borrow occurs. V is set on signed overflow. Opcodes 1 and 3 take their carry-in from the stored C flag.
- R3: Opcode 5 multiplies a by b and returns only the low W bits of the product.
- R4: Logical opcodes are 6 AND, 7 OR, 8 XOR, 9 bit-clear (a AND NOT b) and 10 move-inverse (NOT b).
- R5: Opcodes 11 to 14 shift or rotate operand a by the unsigned 8-bit amount `shamt`. Opcode 11 is a logical left shift and 12 a logical right shift, both filling with zeros and giving zero at amounts of W or more. Opcode 13 is an arithmetic right shift, giving all sign bits at W or more. Opcode 14 rotates right by the amount modulo W.
- R6: A shift or rotate sets C to the last bit shifted out (for a rotate, the new bit W-1). A zero shift amount leaves C unchanged.
- R7: Flags are bit 3 N, bit 2 Z, bit 1 C and bit 0 V of `flags`. Opcodes 0 to 14 write flags only when `set_flags` is high; otherwise all four flags hold. N is result bit W-1, and Z is set when the result is zero. Multiply, logical and shift opcodes keep V. Multiply and logical opcodes keep C.
- R8: Opcode 15 compare (a-b), 16 compare-negative (a+b) and 17 test (a AND b) update the flags regardless of `set_flags`. They hold `wr_en` low and `result` at zero. Test keeps C and V.
- R9: Opcodes 18 to 31, and any cycle with `op_valid` low, give `wr_en` low, `result` zero and unchanged flags.
- R10: A synchronous active-high reset clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation present this cycle |
| opcode | input | 5 | Operation code |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| shamt | input | 8 | Shift or rotate amount |
| set_flags | input | 1 | Request a flag update |
| result | output | W | Operation result |
| wr_en | output | 1 | Result is to be written back |
| flags | output | 4 | Stored N, Z, C, V |

## Verification
Every opcode is crossed with a grid of operands built from zero, one, the signed extremes, all ones and alternating bit patterns. Each combination is run with the stored carry both clear and set. This separates the carry-in paths of the chained operations, and it separates signed overflow from unsigned carry at the boundaries of the number range. Set-flags alternates through the grid, so held flags are told apart from recomputed ones. Shift amounts are swept from 0 to 40 and then up to 255 over several operands. This exposes the zero-amount carry rule, the exact-width case, the over-width fill and the modulo rotate.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [4:0]   opcode,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [7:0]   shamt,
  input  logic         set_flags,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic [3:0]   flags
);
  localparam int LB = $clog2(W);
  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_RSB = 5'd4,  OP_MUL = 5'd5,  OP_AND = 5'd6,  OP_ORR = 5'd7;
  localparam logic [4:0] OP_EOR = 5'd8,  OP_BIC = 5'd9,  OP_MVN = 5'd10, OP_LSL = 5'd11;
  localparam logic [4:0] OP_LSR = 5'd12, OP_ASR = 5'd13, OP_ROR = 5'd14, OP_CMP = 5'd15;
  localparam logic [4:0] OP_CMN = 5'd16, OP_TST = 5'd17;

  logic [W-1:0] add_x, add_y, val, ror_r;
  logic         add_ci, c_nx, v_nx, writes, known;
  logic [W:0]   sum, lsl_w, lsr_w;
  logic signed [W:0] asr_w;
  logic [LB-1:0] ror_n;
  wire          c_cur = flags[1];
  wire          v_cur = flags[0];

  always_comb begin
    add_x  = opnd_a;
    add_y  = opnd_b;
    add_ci = 1'b0;
    case (opcode)
      OP_ADC:         add_ci = c_cur;
      OP_SUB, OP_CMP: begin add_y = ~opnd_b; add_ci = 1'b1; end
      OP_SBC:         begin add_y = ~opnd_b; add_ci = c_cur; end
      OP_RSB:         begin add_x = opnd_b; add_y = ~opnd_a; add_ci = 1'b1; end
      default: ;
    endcase
  end

  assign sum   = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_ci};
  assign lsl_w = {1'b0, opnd_a} << shamt;
  assign lsr_w = {opnd_a, 1'b0} >> shamt;
  assign asr_w = $signed({opnd_a, 1'b0}) >>> shamt;
  assign ror_n = shamt[LB-1:0];
  assign ror_r = (opnd_a >> ror_n) | (opnd_a << (W - int'(ror_n)));
  wire   add_v = (add_x[W-1] == add_y[W-1]) && (sum[W-1] != add_x[W-1]);
  wire   sh0   = (shamt == 8'd0);

  always_comb begin
    val    = '0;
    c_nx   = c_cur;
    v_nx   = v_cur;
    writes = 1'b1;
    known  = 1'b1;
    case (opcode)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_RSB, OP_CMP, OP_CMN: begin
        val  = sum[W-1:0];
        c_nx = sum[W];
        v_nx = add_v;
        writes = !(opcode == OP_CMP || opcode == OP_CMN);
      end
      OP_MUL: val = opnd_a * opnd_b;
      OP_AND: val = opnd_a & opnd_b;
      OP_TST: begin val = opnd_a & opnd_b; writes = 1'b0; end
      OP_ORR: val = opnd_a | opnd_b;
      OP_EOR: val = opnd_a ^ opnd_b;
      OP_BIC: val = opnd_a & ~opnd_b;
      OP_MVN: val = ~opnd_b;
      OP_LSL: begin val = lsl_w[W-1:0]; if (!sh0) c_nx = lsl_w[W]; end
      OP_LSR: begin val = lsr_w[W:1];   if (!sh0) c_nx = lsr_w[0]; end
      OP_ASR: begin val = asr_w[W:1];   if (!sh0) c_nx = asr_w[0]; end
      OP_ROR: begin
        val = sh0 ? opnd_a : ror_r;
        if (!sh0) c_nx = ror_r[W-1];
      end
      default: begin known = 1'b0; writes = 1'b0; end
    endcase
  end

  wire do_wr  = op_valid && known && writes;
  wire upd_fl = op_valid && known && (set_flags || !writes);

  assign wr_en  = do_wr;
  assign result = do_wr ? val : '0;

  always_ff @(posedge clk) begin
    if (rst)          flags <= 4'b0000;
    else if (upd_fl)  flags <= {val[W-1], (val == '0), c_nx, v_nx};
  end

  a_r7_hold_without_request: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || opcode > 5'd17 || (!set_flags && opcode < 5'd15)) |=> $stable(flags));
  a_r8_compare_no_write: assert property (@(posedge clk) disable iff (rst)
    (op_valid && opcode >= 5'd15 && opcode <= 5'd17) |-> (!wr_en && result == '0));
  a_r9_unused_no_write: assert property (@(posedge clk) disable iff (rst)
    (opcode > 5'd17 || !op_valid) |-> !wr_en);
  a_r7_nz_follow_result: assert property (@(posedge clk) disable iff (rst)
    (op_valid && set_flags && opcode < 5'd15) |=>
      (flags[3] == $past(result[W-1]) && flags[2] == ($past(result) == '0)));
  a_r7_keep_v: assert property (@(posedge clk) disable iff (rst)
    (op_valid && opcode >= 5'd5 && opcode <= 5'd14) |=> flags[0] == $past(flags[0]));
  a_r6_zero_shift_keeps_c: assert property (@(posedge clk) disable iff (rst)
    (op_valid && opcode >= 5'd11 && opcode <= 5'd14 && shamt == 8'd0) |=> flags[1] == $past(flags[1]));
endmodule

// File: tb/flag_alu_tb.sv
module flag_alu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0, rst = 1'b1, op_valid = 1'b0, set_flags = 1'b0;
  logic [4:0] opcode = '0;
  logic [W-1:0] opnd_a = '0, opnd_b = '0;
  logic [7:0] shamt = '0;
  logic [W-1:0] result;
  logic wr_en;
  logic [3:0] flags;

  int vectors = 0, miscompares = 0;
  logic [3:0] ef = 4'b0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_alu #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt(shamt), .set_flags(set_flags),
    .result(result), .wr_en(wr_en), .flags(flags));

  function automatic string tag(input logic [4:0] op);
    if (op <= 5'd4) return "R1/R2";
    if (op == 5'd5) return "R3";
    if (op <= 5'd10) return "R4";
    if (op <= 5'd14) return "R5/R6";
    if (op <= 5'd17) return "R8";
    return "R9";
  endfunction

  task automatic model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [7:0] sh, input logic sf, input logic [3:0] fin,
                       output logic [31:0] r, output logic w, output logic [3:0] fo);
    longint sa, sb, ss, ua, ub, us;
    logic [31:0] v;
    logic c, ov, upd, cin;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = longint'(a); ub = longint'(b);
    c = fin[1]; ov = fin[0]; v = '0; w = 1'b1; upd = sf;
    cin = fin[1];
    case (op)
      5'd0, 5'd1, 5'd16: begin
        if (op != 5'd1) cin = 1'b0;
        ss = sa + sb + longint'(cin); us = ua + ub + longint'(cin);
        v = us[31:0]; c = us[32];
        ov = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
      end
      5'd2, 5'd3, 5'd15: begin
        if (op != 5'd3) cin = 1'b1;
        ss = sa - sb - longint'(!cin); us = ua - ub - longint'(!cin);
        v = us[31:0]; c = (us >= 0);
        ov = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
      end
      5'd4: begin
        ss = sb - sa; us = ub - ua;
        v = us[31:0]; c = (us >= 0);
        ov = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
      end
      5'd5: begin us = ua * ub; v = us[31:0]; end
      5'd6, 5'd17: v = a & b;
      5'd7: v = a | b;
      5'd8: v = a ^ b;
      5'd9: v = a & ~b;
      5'd10: v = ~b;
      5'd11, 5'd12, 5'd13, 5'd14: begin
        v = a;
        for (int i = 0; i < int'(sh); i++) begin
          case (op)
            5'd11: begin c = v[31]; v = {v[30:0], 1'b0}; end
            5'd12: begin c = v[0];  v = {1'b0, v[31:1]}; end
            5'd13: begin c = v[0];  v = {v[31], v[31:1]}; end
            default: begin c = v[0]; v = {v[0], v[31:1]}; end
          endcase
        end
      end
      default: begin w = 1'b0; upd = 1'b0; end
    endcase
    if (op >= 5'd15 && op <= 5'd17) begin w = 1'b0; upd = 1'b1; end
    r = w ? v : '0;
    fo = upd ? {v[31], (v == 32'd0), c, ov} : fin;
  endtask

  task automatic run(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic [7:0] sh, input logic sf);
    logic [31:0] er; logic ew; logic [3:0] nf;
    model(op, a, b, sh, sf, ef, er, ew, nf);
    @(negedge clk);
    op_valid = 1'b1; opcode = op; opnd_a = a; opnd_b = b; shamt = sh; set_flags = sf;
    #1;
    vectors++;
    if (result !== er || wr_en !== ew) begin
      miscompares++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d: result=%h wr_en=%b expected %h %b",
               tag(op), op, a, b, sh, result, wr_en, er, ew);
    end
    @(posedge clk); #1;
    ef = nf;
    if (flags !== ef) begin
      miscompares++;
      $display("FAIL %s/R7 op=%0d a=%h b=%h sh=%0d sf=%b: flags=%b expected %b",
               tag(op), op, a, b, sh, sf, flags, ef);
    end
  endtask

  logic [31:0] pats [8] = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000,
                            32'hffffffff, 32'h55555555, 32'haaaaaaaa, 32'h89abcdef};

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    vectors++;
    if (flags !== 4'b0000 || wr_en !== 1'b0 || result !== '0) begin
      miscompares++;
      $display("FAIL R10 after reset: flags=%b wr_en=%b result=%h expected 0000 0 0",
               flags, wr_en, result);
    end
    // R1 R2 R3 R4 R7 R8 R9: opcode x operand grid x stored carry
    for (int op = 0; op < 20; op++)
      for (int ia = 0; ia < 8; ia++)
        for (int ib = 0; ib < 8; ib++)
          for (int cv = 0; cv < 2; cv++) begin
            run(5'd15, cv[0] ? 32'd1 : 32'd0, cv[0] ? 32'd0 : 32'd1, 8'd0, 1'b0);
            run(5'(op), pats[ia], pats[ib], 8'd0, ((ia + ib + cv) % 3) != 0);
          end
    // R5 R6: shift amount sweep, including zero, width and over-width
    for (int op = 11; op < 15; op++)
      for (int ia = 1; ia < 8; ia++)
        for (int s = 0; s < 48; s++) begin
          run(5'd15, 32'd1, 32'd0, 8'd0, 1'b0);
          run(5'(op), pats[ia], 32'h0, (s < 41) ? 8'(s) : 8'(s * 31 + 7), 1'b1);
          run(5'(op), pats[ia] ^ 32'h0f0f0001, 32'h0, (s < 41) ? 8'(s) : 8'(255 - s), 1'b1);
        end
    // R9: op_valid low has no effect
    run(5'd15, 32'd1, 32'd0, 8'd0, 1'b0);
    @(negedge clk);
    op_valid = 1'b0; opcode = 5'd0; opnd_a = 32'd0; opnd_b = 32'd0; set_flags = 1'b1;
    #1; vectors++;
    if (wr_en !== 1'b0 || result !== '0) begin
      miscompares++;
      $display("FAIL R9 idle: wr_en=%b result=%h expected 0 0", wr_en, result);
    end
    @(posedge clk); #1; vectors++;
    if (flags !== ef) begin
      miscompares++;
      $display("FAIL R9 idle flags=%b expected %b", flags, ef);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule